// File: doc/BRIEF.md
# Shared Reset / NMI Pin Controller

This block governs one external pin that serves either as an active-low device reset or as an edge-triggered non-maskable interrupt source. The raw pin level is brought into the clock domain through a two-stage synchronizer. In reset function the synchronized level feeds a glitch filter. The filter requests a device reset only once the pin has been held low for `FILTER_CYCLES` consecutive clock cycles. In interrupt function the filter is disabled and an edge detector sets a sticky interrupt flag on the selected edge. An interrupt request leaves the block while both the flag and the enable bit are set. The same configuration word also drives the pad's pull-resistor direction and enable.

Software writes a five-bit configuration word with `reg_we` and reads it back, together with the flag, on `reg_rdata`. The flag is cleared with a one-cycle `flag_clr` strobe. A new edge in the same cycle as the clear wins, so no event is lost. A write that changes the function or the edge polarity masks edge detection for that cycle, so reconfiguration cannot create a false event. The edge history is still captured in that cycle.

Two state machines make up the block. The glitch filter has states FLT_IDLE, FLT_QUAL and FLT_HOLD:
- FLT_IDLE moves to FLT_QUAL on the first low sample in reset function.
- FLT_QUAL counts low samples. It moves to FLT_HOLD when the count reaches `FILTER_CYCLES`, and falls back to FLT_IDLE on a high sample or in interrupt function.
- FLT_HOLD drives the reset request. It returns to FLT_IDLE on a high sample or in interrupt function.

The edge tracker has states EDG_LOW and EDG_HIGH. Each cycle it moves to the state of the current level. A move from EDG_LOW to EDG_HIGH is a rising edge, and a move from EDG_HIGH to EDG_LOW is a falling edge.

Top module: `rnp_pin_ctrl`

## Requirements
- R1: While `por_n` is low and after it is released, the configuration is the default: reset function, rising edge, interrupt disabled, pull-up selected, pull enabled. The outputs are `reg_rdata` = 6'b011000, `rst_req` = 0, `nmi_flag` = 0, `pull_up_sel` = 1 and `pull_enable` = 1.
- R2: When `reg_we` is high at a clock edge, `reg_wdata` is loaded with this bit layout: bit 0 selects the function (1 = interrupt), bit 1 selects the polarity (1 = falling, 0 = rising), bit 2 is the interrupt enable, bit 3 is the pull direction (1 = up) and bit 4 is the pull enable. `reg_rdata[4:0]` shows the stored word from the next cycle, and `reg_rdata[5]` shows the flag.
- R3: In reset function, `rst_req` rises after the clock edge at which the synchronized pin has been sampled low `FILTER_CYCLES` times in a row. That edge is `FILTER_CYCLES`+2 edges after the raw pin goes low. `rst_req` falls after the first edge that samples the pin high again.
- R4: A low pulse shorter than `FILTER_CYCLES` cycles never asserts `rst_req`.
- R5: In interrupt function, the filter is off and `rst_req` stays low, however long the pin is held low.
- R6: In interrupt function, the selected edge of the synchronized pin sets `nmi_flag` three clock edges after the raw pin changes. The opposite edge has no effect on the flag.
- R7: `nmi_irq` is high exactly when `nmi_flag` and the interrupt enable bit are both set.
- R8: A high `flag_clr` clears `nmi_flag` at the next edge. If a valid edge is detected in the same cycle, the flag stays set.
- R9: In a cycle where `reg_we` writes a value that changes bit 0 or bit 1, no edge event is detected.
- R10: `pull_up_sel` and `pull_enable` follow configuration bits 3 and 4.
- R11: Pin edges in reset function never set `nmi_flag`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| por_n | input | 1 | Active-low power-on / brownout reset, asynchronous |
| pin_raw | input | 1 | Asynchronous level of the shared pin |
| reg_we | input | 1 | Configuration write strobe |
| reg_wdata | input | 5 | Configuration write data |
| flag_clr | input | 1 | Interrupt flag clear strobe |
| reg_rdata | output | 6 | Read-back: flag in bit 5, configuration in bits 4:0 |
| rst_req | output | 1 | Filtered device reset request, active high |
| nmi_flag | output | 1 | Sticky interrupt flag |
| nmi_irq | output | 1 | Interrupt request to the CPU |
| pull_up_sel | output | 1 | Pad pull direction, 1 = pull-up |
| pull_enable | output | 1 | Pad pull resistor enable |

## Verification
The assertions take `FILTER_CYCLES` to be at least 2. They also take `reg_we`, `reg_wdata` and `flag_clr` to be synchronous to `clk`, while `pin_raw` may change in any cycle. The bench drives every input on the falling clock edge, so each is stable at the rising edge, and it holds `por_n` low across several rising edges. The edge-masking property assumes that a write changing the function or polarity happens only once per cycle. The directed cases line up flag clears and configuration writes with the exact cycle in which an edge reaches the detector, so that these cases meet the masking and clear-priority logic.

// File: rtl/rnp_pkg.sv
package rnp_pkg;
    localparam int CFG_W = 5;

    typedef struct packed {
        logic pull_on;
        logic pull_up;
        logic irq_en;
        logic edge_fall;
        logic nmi_mode;
    } rnp_cfg_t;

    localparam rnp_cfg_t CFG_DEFAULT = '{pull_on: 1'b1, pull_up: 1'b1,
                                         irq_en: 1'b0, edge_fall: 1'b0,
                                         nmi_mode: 1'b0};

    typedef enum logic [1:0] {
        FLT_IDLE,
        FLT_QUAL,
        FLT_HOLD
    } flt_state_t;

    typedef enum logic {
        EDG_LOW,
        EDG_HIGH
    } edg_state_t;
endpackage

// File: rtl/rnp_sync.sv
module rnp_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic por_n,
    input  logic d_async,
    output logic q_sync
);
    logic [STAGES-1:0] chain_q;

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) chain_q <= '1;
        else        chain_q <= {chain_q[STAGES-2:0], d_async};
    end

    assign q_sync = chain_q[STAGES-1];
endmodule

// File: rtl/rnp_cfg.sv
module rnp_cfg
    import rnp_pkg::*;
(
    input  logic     clk,
    input  logic     por_n,
    input  logic     wr_en,
    input  rnp_cfg_t wr_word,
    output rnp_cfg_t cfg_q,
    output logic     cfg_change
);
    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n)     cfg_q <= CFG_DEFAULT;
        else if (wr_en) cfg_q <= wr_word;
    end

    always_comb begin
        cfg_change = wr_en && ((wr_word.nmi_mode != cfg_q.nmi_mode) ||
                               (wr_word.edge_fall != cfg_q.edge_fall));
    end
endmodule

// File: rtl/rnp_filter.sv
module rnp_filter
    import rnp_pkg::*;
#(
    parameter int FILTER_CYCLES = 32
) (
    input  logic clk,
    input  logic por_n,
    input  logic pin_s,
    input  logic nmi_mode,
    output logic rst_req
);
    localparam int CNT_W = $clog2(FILTER_CYCLES + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(FILTER_CYCLES - 1);

    flt_state_t       state_q, state_n;
    logic [CNT_W-1:0] cnt_q, cnt_n;
    logic             leave;

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            state_q <= FLT_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_n;
            cnt_q   <= cnt_n;
        end
    end

    always_comb begin
        leave   = nmi_mode || pin_s;
        state_n = state_q;
        cnt_n   = cnt_q;
        unique case (state_q)
            FLT_IDLE: begin
                if (!leave) begin
                    state_n = FLT_QUAL;
                    cnt_n   = CNT_W'(1);
                end
            end
            FLT_QUAL: begin
                if (leave) begin
                    state_n = FLT_IDLE;
                    cnt_n   = '0;
                end else if (cnt_q == LAST) begin
                    state_n = FLT_HOLD;
                end else begin
                    cnt_n = cnt_q + CNT_W'(1);
                end
            end
            FLT_HOLD: begin
                if (leave) begin
                    state_n = FLT_IDLE;
                    cnt_n   = '0;
                end
            end
            default: begin
                state_n = FLT_IDLE;
                cnt_n   = '0;
            end
        endcase
    end

    always_comb begin
        rst_req = (state_q == FLT_HOLD);
    end
endmodule

// File: rtl/rnp_nmi_edge.sv
module rnp_nmi_edge
    import rnp_pkg::*;
(
    input  logic clk,
    input  logic por_n,
    input  logic pin_s,
    input  logic nmi_mode,
    input  logic edge_fall,
    input  logic cfg_change,
    input  logic flag_clr,
    output logic flag_q
);
    edg_state_t state_q, state_n;
    logic       rise, fall, hit;

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            state_q <= EDG_HIGH;
            flag_q  <= 1'b0;
        end else begin
            state_q <= state_n;
            flag_q  <= hit || (flag_q && !flag_clr);
        end
    end

    always_comb begin
        rise    = 1'b0;
        fall    = 1'b0;
        state_n = state_q;
        unique case (state_q)
            EDG_LOW: begin
                if (pin_s) begin
                    state_n = EDG_HIGH;
                    rise    = 1'b1;
                end
            end
            EDG_HIGH: begin
                if (!pin_s) begin
                    state_n = EDG_LOW;
                    fall    = 1'b1;
                end
            end
            default: state_n = EDG_HIGH;
        endcase
        hit = nmi_mode && !cfg_change && (edge_fall ? fall : rise);
    end
endmodule

// File: rtl/rnp_pin_ctrl.sv
module rnp_pin_ctrl
    import rnp_pkg::*;
#(
    parameter int FILTER_CYCLES = 32,
    parameter int SYNC_STAGES   = 2
) (
    input  logic             clk,
    input  logic             por_n,
    input  logic             pin_raw,
    input  logic             reg_we,
    input  logic [CFG_W-1:0] reg_wdata,
    input  logic             flag_clr,
    output logic [CFG_W:0]   reg_rdata,
    output logic             rst_req,
    output logic             nmi_flag,
    output logic             nmi_irq,
    output logic             pull_up_sel,
    output logic             pull_enable
);
    logic     pin_s;
    logic     cfg_change;
    rnp_cfg_t cfg_q;

    rnp_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .por_n(por_n), .d_async(pin_raw), .q_sync(pin_s)
    );

    rnp_cfg u_cfg (
        .clk(clk), .por_n(por_n), .wr_en(reg_we), .wr_word(rnp_cfg_t'(reg_wdata)),
        .cfg_q(cfg_q), .cfg_change(cfg_change)
    );

    rnp_filter #(.FILTER_CYCLES(FILTER_CYCLES)) u_filter (
        .clk(clk), .por_n(por_n), .pin_s(pin_s), .nmi_mode(cfg_q.nmi_mode),
        .rst_req(rst_req)
    );

    rnp_nmi_edge u_edge (
        .clk(clk), .por_n(por_n), .pin_s(pin_s), .nmi_mode(cfg_q.nmi_mode),
        .edge_fall(cfg_q.edge_fall), .cfg_change(cfg_change),
        .flag_clr(flag_clr), .flag_q(nmi_flag)
    );

    always_comb begin
        nmi_irq     = nmi_flag && cfg_q.irq_en;
        pull_up_sel = cfg_q.pull_up;
        pull_enable = cfg_q.pull_on;
        reg_rdata   = {nmi_flag, cfg_q};
    end
endmodule

// File: rtl/rnp_checker.sv
module rnp_checker #(
    parameter int FILTER_CYCLES = 32
) (
    input logic       clk,
    input logic       por_n,
    input logic       pin_s,
    input logic       cfg_nmi,
    input logic [1:0] cfg_me,
    input logic       reg_we,
    input logic [1:0] wr_me,
    input logic       flag_clr,
    input logic       rst_req,
    input logic       nmi_flag,
    input logic       nmi_irq
);
    int unsigned low_run;

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n)                 low_run <= 0;
        else if (!cfg_nmi && !pin_s) begin
            if (low_run < FILTER_CYCLES + 4) low_run <= low_run + 1;
        end else                    low_run <= 0;
    end

    assert_filter_width_R3: assert property (@(posedge clk) disable iff (!por_n)
        $rose(rst_req) |-> (low_run >= FILTER_CYCLES));

    assert_nmi_no_reset_R5: assert property (@(posedge clk) disable iff (!por_n)
        cfg_nmi |=> !rst_req);

    assert_flag_from_nmi_R6: assert property (@(posedge clk) disable iff (!por_n)
        $rose(nmi_flag) |-> $past(cfg_nmi));

    assert_irq_needs_flag_R7: assert property (@(posedge clk) disable iff (!por_n)
        nmi_irq |-> nmi_flag);

    assert_flag_sticky_R8: assert property (@(posedge clk) disable iff (!por_n)
        (nmi_flag && !flag_clr) |=> nmi_flag);

    assert_cfg_quiet_R9: assert property (@(posedge clk) disable iff (!por_n)
        (reg_we && (wr_me != cfg_me)) |=> !$rose(nmi_flag));
endmodule

bind rnp_pin_ctrl rnp_checker #(.FILTER_CYCLES(FILTER_CYCLES)) u_chk (
    .clk(clk), .por_n(por_n), .pin_s(pin_s), .cfg_nmi(cfg_q.nmi_mode),
    .cfg_me({cfg_q.edge_fall, cfg_q.nmi_mode}), .reg_we(reg_we),
    .wr_me(reg_wdata[1:0]), .flag_clr(flag_clr), .rst_req(rst_req),
    .nmi_flag(nmi_flag), .nmi_irq(nmi_irq)
);

// File: tb/rnp_pin_ctrl_test.sv
module rnp_pin_ctrl_test;
    localparam int FC = 32;

    logic       clk = 1'b0;
    logic       por_n = 1'b0;
    logic       pin_raw = 1'b1;
    logic       reg_we = 1'b0;
    logic [4:0] reg_wdata = 5'b0;
    logic       flag_clr = 1'b0;
    logic [5:0] reg_rdata;
    logic       rst_req, nmi_flag, nmi_irq, pull_up_sel, pull_enable;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // behavioural reference state
    bit       m_s1, m_s2, m_prev, m_flag, m_rst;
    bit [4:0] m_cfg;
    int       m_run;

    always #5 clk = ~clk;

    rnp_pin_ctrl #(.FILTER_CYCLES(FC)) uut (
        .clk(clk), .por_n(por_n), .pin_raw(pin_raw), .reg_we(reg_we),
        .reg_wdata(reg_wdata), .flag_clr(flag_clr), .reg_rdata(reg_rdata),
        .rst_req(rst_req), .nmi_flag(nmi_flag), .nmi_irq(nmi_irq),
        .pull_up_sel(pull_up_sel), .pull_enable(pull_enable)
    );

    task automatic chk(input int act, input int exp, input string req);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [4:0] w);
        reg_we = 1'b1;
        reg_wdata = w;
        tick(1);
        reg_we = 1'b0;
    endtask

    always @(posedge clk) begin
        bit chg, ev;
        if (!por_n) begin
            m_s1 = 1; m_s2 = 1; m_prev = 1; m_flag = 0; m_rst = 0;
            m_cfg = 5'b11000; m_run = 0;
        end else begin
            chg = reg_we && (reg_wdata[1:0] != m_cfg[1:0]);
            ev = m_cfg[0] && !chg &&
                 (m_cfg[1] ? (m_prev && !m_s2) : (!m_prev && m_s2));
            m_flag = ev || (m_flag && !flag_clr);
            if (!m_cfg[0] && !m_s2) m_run++;
            else                    m_run = 0;
            m_rst = (m_run >= FC);
            m_prev = m_s2;
            m_s2 = m_s1;
            m_s1 = pin_raw;
            if (reg_we) m_cfg = reg_wdata;
        end
    end

    always @(negedge clk) begin
        if (por_n && !done) begin
            chk(rst_req, m_rst, "R3 model rst_req");
            chk(nmi_flag, m_flag, "R6 model nmi_flag");
            chk(nmi_irq, m_flag && m_cfg[2], "R7 model nmi_irq");
            chk(pull_up_sel, m_cfg[3], "R10 model pull_up_sel");
            chk(pull_enable, m_cfg[4], "R10 model pull_enable");
            chk(reg_rdata, {m_flag, m_cfg}, "R2 model reg_rdata");
        end
    end

    initial begin
        tick(3);
        chk(reg_rdata, 6'b011000, "R1 rdata in reset");
        chk(rst_req, 0, "R1 rst_req in reset");
        chk(pull_up_sel, 1, "R1 pull_up_sel");
        chk(pull_enable, 1, "R1 pull_enable");
        por_n = 1'b1;
        tick(2);
        chk(reg_rdata, 6'b011000, "R1 rdata after release");

        // short pulse
        pin_raw = 1'b0; tick(FC - 12);
        chk(rst_req, 0, "R4 during short pulse");
        pin_raw = 1'b1; tick(4);
        chk(rst_req, 0, "R4 after short pulse");

        // long pulse
        pin_raw = 1'b0; tick(FC + 1);
        chk(rst_req, 0, "R3 not early");
        tick(1);
        chk(rst_req, 1, "R3 asserted");
        pin_raw = 1'b1; tick(2);
        chk(rst_req, 1, "R3 held through sync");
        tick(1);
        chk(rst_req, 0, "R3 released");
        chk(nmi_flag, 0, "R11 edges in reset mode");

        // interrupt mode, rising edge, irq disabled
        wr(5'b11001);
        chk(reg_rdata, 6'b011001, "R2 write visible");
        pin_raw = 1'b0; tick(FC + 8);
        chk(rst_req, 0, "R5 no reset in nmi mode");
        chk(nmi_flag, 0, "R6 falling ignored when rising selected");
        pin_raw = 1'b1; tick(2);
        chk(nmi_flag, 0, "R6 not before third edge");
        tick(1);
        chk(nmi_flag, 1, "R6 rising edge sets flag");
        chk(nmi_irq, 0, "R7 masked");
        wr(5'b11101);
        chk(nmi_irq, 1, "R7 enabled");

        flag_clr = 1'b1; tick(1); flag_clr = 1'b0;
        chk(nmi_flag, 0, "R8 cleared");
        chk(nmi_irq, 0, "R7 drops with flag");

        // falling mode, clear collides with edge
        wr(5'b11111);
        pin_raw = 1'b0; tick(2);
        flag_clr = 1'b1; tick(1); flag_clr = 1'b0;
        chk(nmi_flag, 1, "R8 edge beats clear");
        flag_clr = 1'b1; tick(1); flag_clr = 1'b0;
        chk(nmi_flag, 0, "R8 cleared again");

        // polarity write in the edge cycle masks the event
        wr(5'b11101);
        pin_raw = 1'b1; tick(2);
        reg_we = 1'b1; reg_wdata = 5'b11111; tick(1); reg_we = 1'b0;
        tick(3);
        chk(nmi_flag, 0, "R9 masked by cfg change");

        // pull controls
        wr(5'b00101);
        chk(pull_up_sel, 0, "R10 pull down");
        chk(pull_enable, 0, "R10 pull off");
        wr(5'b10000);
        chk(pull_enable, 1, "R10 pull on");
        chk(pull_up_sel, 0, "R10 pull still down");
        tick(2);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule